// File: doc/BRIEF.md
# Doorbell and Interrupt Register Bank

This block is the control register bank of a shared-memory device that several agents use to talk to each other. Software sees four 32-bit words in a 256-byte window. Two of them form a level interrupt: a status word that local events or software set, and a mask word that selects which status bits may raise the interrupt line. A read of the status word returns it and clears it, which acknowledges the interrupt. One read-only word reports this agent's own peer number.

The fourth word is a doorbell. Software writes a destination peer and a vector number into it. The bank checks that pair against two limits: how many peers are configured, and how many vectors the destination peer has registered. If the pair passes, the bank sends a one-cycle notify pulse carrying the peer and vector. If it fails, the write is dropped without any notification.

The interrupt line is used only in pin mode. When message signalling is selected, or no interrupt pin is configured, the line stays low, and local events no longer change the status word. The notify output has no ready signal and cannot be held back. Whatever consumes it must accept a pulse in any cycle, so the rate is at most one pulse per doorbell write.

Top module: `shm_bell_regs`

## Requirements
- R1: After reset the mask and status words are zero, `irq` and `bell_stb` are low and `reg_rdata` is zero. Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled high and holds until the next read.
- R2: The mask word sits at offset 0x00. A write replaces all 32 bits, and a later read returns them.
- R3: With `cfg_msi` low and `cfg_pin_en` high, `irq` is high exactly when the bitwise AND of status and mask is nonzero. It follows a register update in the same cycle that the update takes effect.
- R4: The status word sits at offset 0x04. A read returns its current value and clears it to zero in the same edge, so `irq` falls unless a write or an event lands in that cycle.
- R5: A write to offset 0x04 replaces the whole status word, including bits that were already set.
- R6: While `cfg_msi` is high, or while `cfg_pin_en` is low, `irq` stays low whatever the status and mask hold.
- R7: A `local_event` pulse with `cfg_msi` low loads the value 1 into the status word. This takes priority over a bus write or a read-clear in the same cycle. With `cfg_msi` high the pulse is ignored.
- R8: A write to offset 0x0C takes the destination peer from bits [31:16] and the vector from bits [7:0]; bits [15:8] are ignored. If the write is accepted, `bell_stb` is high for exactly the one cycle after the write edge, with `bell_peer` and `bell_vec` set to those fields.
- R9: A doorbell write whose destination peer is greater than or equal to `cfg_peer_count` produces no pulse.
- R10: A doorbell write whose vector is greater than or equal to the destination's registered count produces no pulse. Peer p's count is held in `cfg_vec_counts[p*9 +: 9]`.
- R11: Offset 0x08 reads `cfg_local_id` zero-extended, and writes to it are ignored. Offset 0x0C reads as zero. Every other offset reads zero, and writes to it change nothing.
- R12: Only whole, aligned words are decoded. An access whose address has a nonzero bit 1 or bit 0 reads zero, has no side effect, and its writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address within the window |
| reg_wr | input | 1 | Write enable |
| reg_rd | input | 1 | Read enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| cfg_msi | input | 1 | Message signalling selected; disables the interrupt line and local events |
| cfg_pin_en | input | 1 | Interrupt pin configured |
| cfg_local_id | input | 16 | This agent's peer number |
| cfg_peer_count | input | clog2(MAX_PEERS+1) | Number of valid destination peers |
| cfg_vec_counts | input | MAX_PEERS*9 | Registered vector count per peer, 9 bits each |
| local_event | input | 1 | Incoming event for this agent |
| bell_stb | output | 1 | One-cycle notify pulse |
| bell_peer | output | 16 | Notify destination peer |
| bell_vec | output | 8 | Notify vector |
| irq | output | 1 | Level interrupt |

## Verification
Doorbell writes are sent to valid peer and vector pairs on both sides of each limit. The tests use a vector exactly one below the count, a vector exactly at the count, a peer with zero registered vectors, a peer exactly at the peer count, and an all-ones peer number. Together these show whether the comparisons are strict and whether the count table is indexed by the right peer. Status and mask are loaded with overlapping and non-overlapping bit patterns, which separates an AND reduction from an OR or a plain status test. Repeated reads then show that the status clear happens on the read and not before it. The mode inputs are toggled with status and mask held fixed, and local events are issued in both modes, so that gating is distinguished from clearing. Unmapped and misaligned accesses are followed by read-back of the real registers.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int DATA_W  = 32;
  localparam int PEER_W  = 16;
  localparam int VEC_W   = 8;
  localparam int VCNT_W  = VEC_W + 1;

  localparam int OFS_MASK   = 'h00;
  localparam int OFS_STATUS = 'h04;
  localparam int OFS_PEERID = 'h08;
  localparam int OFS_BELL   = 'h0C;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_MASK,
    RK_STATUS,
    RK_PEERID,
    RK_BELL
  } reg_kind_e;
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
  import dbr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind
);
  localparam int WORD_W = ADDR_W - 2;

  logic              aligned;
  logic [WORD_W-1:0] word;

  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[ADDR_W-1:2];

  always_comb begin
    kind = RK_NONE;
    if (aligned) begin
      if (word == WORD_W'(OFS_MASK / 4))        kind = RK_MASK;
      else if (word == WORD_W'(OFS_STATUS / 4)) kind = RK_STATUS;
      else if (word == WORD_W'(OFS_PEERID / 4)) kind = RK_PEERID;
      else if (word == WORD_W'(OFS_BELL / 4))   kind = RK_BELL;
    end
  end
endmodule

// File: rtl/dbr_irq_regs.sv
module dbr_irq_regs
  import dbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic              stat_we,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              event_in,
  input  logic              msi_mode,
  input  logic              pin_en,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] status_q,
  output logic              irq
);
  logic              take_event;
  logic [DATA_W-1:0] status_d;

  assign take_event = event_in && !msi_mode;

  always_comb begin
    status_d = status_q;
    if (take_event)   status_d = DATA_W'(1);
    else if (stat_we) status_d = wdata;
    else if (stat_rd) status_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (mask_we) mask_q <= wdata;
      status_q <= status_d;
    end
  end

  assign irq = !msi_mode && pin_en && (|(status_q & mask_q));
endmodule

// File: rtl/dbr_bell_gate.sv
module dbr_bell_gate
  import dbr_pkg::*;
#(
  parameter int MAX_PEERS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  logic [PEER_W-1:0]           dest,
  input  logic [VEC_W-1:0]            vec,
  input  logic [$clog2(MAX_PEERS+1)-1:0] peer_count,
  input  logic [MAX_PEERS*VCNT_W-1:0] vec_counts,
  output logic                        stb,
  output logic [PEER_W-1:0]           stb_peer,
  output logic [VEC_W-1:0]            stb_vec
);
  logic [VCNT_W-1:0] cnt_tab [MAX_PEERS];
  logic [VCNT_W-1:0] dest_cnt;
  logic              peer_ok;
  logic              vec_ok;

  for (genvar p = 0; p < MAX_PEERS; p++) begin : g_tab
    assign cnt_tab[p] = vec_counts[p*VCNT_W +: VCNT_W];
  end

  always_comb begin
    dest_cnt = '0;
    for (int p = 0; p < MAX_PEERS; p++) begin
      if (dest == PEER_W'(p)) dest_cnt = cnt_tab[p];
    end
  end

  assign peer_ok = dest < PEER_W'(peer_count);
  assign vec_ok  = {1'b0, vec} < dest_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb      <= 1'b0;
      stb_peer <= '0;
      stb_vec  <= '0;
    end else begin
      stb <= fire && peer_ok && vec_ok;
      if (fire) begin
        stb_peer <= dest;
        stb_vec  <= vec;
      end
    end
  end
endmodule

// File: rtl/shm_bell_regs.sv
module shm_bell_regs
  import dbr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAX_PEERS = 4,
  localparam int PCNT_W   = $clog2(MAX_PEERS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  input  logic                        cfg_msi,
  input  logic                        cfg_pin_en,
  input  logic [15:0]                 cfg_local_id,
  input  logic [PCNT_W-1:0]           cfg_peer_count,
  input  logic [MAX_PEERS*9-1:0]      cfg_vec_counts,
  input  logic                        local_event,
  output logic                        bell_stb,
  output logic [15:0]                 bell_peer,
  output logic [7:0]                  bell_vec,
  output logic                        irq
);
  reg_kind_e         kind;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] status_q;

  dbr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .kind (kind)
  );

  dbr_irq_regs u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_we  (reg_wr && kind == RK_MASK),
    .stat_we  (reg_wr && kind == RK_STATUS),
    .stat_rd  (reg_rd && kind == RK_STATUS),
    .wdata    (reg_wdata),
    .event_in (local_event),
    .msi_mode (cfg_msi),
    .pin_en   (cfg_pin_en),
    .mask_q   (mask_q),
    .status_q (status_q),
    .irq      (irq)
  );

  dbr_bell_gate #(.MAX_PEERS(MAX_PEERS)) u_bell (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (reg_wr && kind == RK_BELL),
    .dest       (reg_wdata[31:16]),
    .vec        (reg_wdata[7:0]),
    .peer_count (cfg_peer_count),
    .vec_counts (cfg_vec_counts),
    .stb        (bell_stb),
    .stb_peer   (bell_peer),
    .stb_vec    (bell_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (kind)
        RK_MASK:   reg_rdata <= mask_q;
        RK_STATUS: reg_rdata <= status_q;
        RK_PEERID: reg_rdata <= DATA_W'(cfg_local_id);
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dbr_checker.sv
module dbr_checker
  import dbr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAX_PEERS = 4,
  localparam int PCNT_W   = $clog2(MAX_PEERS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [31:0]       reg_wdata,
  input logic              cfg_msi,
  input logic              cfg_pin_en,
  input logic [PCNT_W-1:0] cfg_peer_count,
  input logic              local_event,
  input logic              bell_stb,
  input logic [15:0]       bell_peer,
  input logic              irq,
  input logic [31:0]       mask_q,
  input logic [31:0]       status_q
);
  AST_MSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_msi |-> !irq); // R6
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pin_en |-> !irq); // R6
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_msi && cfg_pin_en && (status_q & mask_q) != 0) |-> irq); // R3
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_MASK)) |=> mask_q == $past(reg_wdata)); // R2
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == ADDR_W'(OFS_STATUS) && !(local_event && !cfg_msi))
      |=> status_q == 0); // R4
  AST_EVENT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (local_event && !cfg_msi) |=> status_q == 32'd1); // R7
  AST_BELL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bell_stb |-> ($past(reg_wr) && $past(reg_addr) == ADDR_W'(OFS_BELL))); // R8
  AST_BELL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bell_stb |-> bell_peer < 16'($past(cfg_peer_count))); // R9
endmodule

bind shm_bell_regs dbr_checker #(.ADDR_W(ADDR_W), .MAX_PEERS(MAX_PEERS)) u_chk (.*);

// File: tb/tb_shm_bell_regs.sv
module tb_shm_bell_regs;
  localparam int ADDR_W = 8;
  localparam int MAXP   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cfg_msi = 1'b0;
  logic        cfg_pin_en = 1'b1;
  logic [15:0] cfg_local_id = 16'h0002;
  logic [2:0]  cfg_peer_count = 3'd3;
  logic [35:0] cfg_vec_counts = {9'd7, 9'd5, 9'd0, 9'd2};
  logic        local_event = 1'b0;
  logic        bell_stb;
  logic [15:0] bell_peer;
  logic [7:0]  bell_vec;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic rd_d = 1'b0;

  logic [31:0] exp_rd_q[$];
  string       exp_rd_tag[$];
  logic [23:0] exp_bell_q[$];

  always #4 clk = ~clk;

  shm_bell_regs #(.ADDR_W(ADDR_W), .MAX_PEERS(MAXP)) dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int vcount(input int p);
    return int'(cfg_vec_counts[p*9 +: 9]);
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    if (a == 8'h0C && int'(d[31:16]) < int'(cfg_peer_count) && int'(d[7:0]) < vcount(int'(d[31:16])))
      exp_bell_q.push_back({d[31:16], d[7:0]});
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    exp_rd_q.push_back(e);
    exp_rd_tag.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_event();
    @(negedge clk);
    local_event = 1'b1;
    @(negedge clk);
    local_event = 1'b0;
  endtask

  always @(posedge clk) rd_d <= reg_rd;

  always @(negedge clk) begin
    if (rst_n && rd_d) begin
      if (exp_rd_q.size() == 0) check(1'b0, "R1 unexpected read", reg_rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_rd_q.pop_front();
        t = exp_rd_tag.pop_front();
        check(reg_rdata === e, t, reg_rdata, e);
      end
    end
    if (rst_n && bell_stb) begin
      if (exp_bell_q.size() == 0)
        check(1'b0, "R9/R10 unexpected notify", {8'h0, bell_peer, bell_vec}, 0);
      else begin
        logic [23:0] e;
        e = exp_bell_q.pop_front();
        check({bell_peer, bell_vec} === e, "R8 notify fields", {8'h0, bell_peer, bell_vec}, {8'h0, e});
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    check(1'b0, "watchdog", 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq === 1'b0 && bell_stb === 1'b0 && reg_rdata === 32'h0, "R1 reset outputs",
          {29'h0, irq, bell_stb, 1'b0}, 0);
    rst_n = 1'b1;
    bus_rd(8'h00, 32'h0, "R1 mask reset");
    bus_rd(8'h04, 32'h0, "R1 status reset");

    bus_wr(8'h00, 32'hFFFF_0003);
    bus_rd(8'h00, 32'hFFFF_0003, "R2 mask readback");

    bus_wr(8'h04, 32'h0000_0002);
    check(irq === 1'b1, "R3 overlap raises irq", {31'h0, irq}, 1);
    bus_wr(8'h04, 32'h0000_0004);
    check(irq === 1'b0, "R5 status replaced, no overlap", {31'h0, irq}, 0);
    bus_rd(8'h04, 32'h0000_0004, "R5 status holds written value");
    bus_rd(8'h04, 32'h0, "R4 status cleared by read");

    bus_wr(8'h04, 32'h0000_0001);
    check(irq === 1'b1, "R3 bit0 raises irq", {31'h0, irq}, 1);
    bus_rd(8'h04, 32'h0000_0001, "R4 read returns value");
    check(irq === 1'b0, "R4 irq drops after read", {31'h0, irq}, 0);

    pulse_event();
    check(irq === 1'b1, "R7 event raises irq", {31'h0, irq}, 1);
    bus_rd(8'h04, 32'h0000_0001, "R7 event loads one");

    bus_wr(8'h04, 32'h0000_0003);
    cfg_msi = 1'b1; #1;
    check(irq === 1'b0, "R6 msi mode quiet", {31'h0, irq}, 0);
    cfg_msi = 1'b0; #1;
    check(irq === 1'b1, "R6 pin mode restores", {31'h0, irq}, 1);
    cfg_pin_en = 1'b0; #1;
    check(irq === 1'b0, "R6 no pin quiet", {31'h0, irq}, 0);
    cfg_pin_en = 1'b1;
    bus_rd(8'h04, 32'h0000_0003, "R6 gating keeps status");

    cfg_msi = 1'b1;
    pulse_event();
    bus_rd(8'h04, 32'h0, "R7 event ignored in msi mode");
    cfg_msi = 1'b0;

    bus_wr(8'h0C, 32'h0002_0004);
    @(negedge clk);
    check(bell_stb === 1'b0, "R8 pulse single cycle", {31'h0, bell_stb}, 0);
    bus_wr(8'h0C, 32'h0000_AB01);
    bus_wr(8'h0C, 32'h0003_0000);
    bus_wr(8'h0C, 32'hFFFF_0000);
    bus_wr(8'h0C, 32'h0002_0005);
    bus_wr(8'h0C, 32'h0001_0000);
    bus_wr(8'h0C, 32'h0000_0002);
    repeat (2) @(negedge clk);
    check(exp_bell_q.size() == 0, "R9/R10 all expected notifies seen", exp_bell_q.size(), 0);

    bus_rd(8'h08, 32'h0000_0002, "R11 peer id read");
    bus_wr(8'h08, 32'h0000_0055);
    bus_rd(8'h08, 32'h0000_0002, "R11 peer id write ignored");
    bus_rd(8'h0C, 32'h0, "R11 doorbell reads zero");
    bus_wr(8'h40, 32'h1234_5678);
    bus_rd(8'h40, 32'h0, "R11 unmapped reads zero");
    bus_rd(8'h00, 32'hFFFF_0003, "R11 unmapped write ignored");
    bus_wr(8'h01, 32'h0000_0000);
    bus_rd(8'h00, 32'hFFFF_0003, "R12 misaligned write ignored");
    bus_wr(8'h04, 32'h0000_0008);
    bus_rd(8'h06, 32'h0, "R12 misaligned read zero");
    bus_rd(8'h04, 32'h0000_0008, "R12 misaligned read no clear");

    repeat (3) @(negedge clk);
    check(exp_rd_q.size() == 0, "R1 all reads returned", exp_rd_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule